// File: doc/BRIEF.md
# Page Write-Protection Gate

This block stands between a unit that requests page writes and a nonvolatile memory that is addressed by an 8-bit page number. Two window inputs mark a half-open range of pages that may not be written. The range runs from a lock page, which is inside the range, up to an open page, which is outside it. A write request aimed at a page inside the range is refused in the cycle it is made. Every other request is passed on to the memory as a one-cycle strobe. The block then stays busy for a fixed, parameterized number of cycles while the memory programs the page.

An abort input can cut a busy write short. An 8-bit read-only status byte keeps two sticky failure flags: one for a refused (protected) write and one for an aborted write. Reading the byte does not clear them. Both flags clear only when a later write runs its full busy time with no abort.

Top module: `wprot_gate`

## Requirements
- R1: After reset the status byte reads 00h, `wr_busy` is low, and no write strobe is issued.
- R2: An idle request for a page p with lock_pg <= p < open_pg (unsigned compare) gets `wr_ack` and `wr_err` high in the same cycle, and `mem_wr_stb` stays low.
- R3: The lock page itself is refused. The open page and every page above it are accepted.
- R4: When open_pg <= lock_pg, no page is refused. This includes the reset-like setting 00h/00h.
- R5: An accepted request gets `wr_ack` high with `wr_err` low, and `mem_wr_stb` high with `mem_wr_page` equal to the request page, all in the same cycle. `wr_busy` is then high for exactly WR_CYCLES cycles, starting the next cycle.
- R6: A request made while `wr_busy` is high gets no `wr_ack` and causes no strobe.
- R7: A refused request sets status bit 1 (page-protected) on the next clock edge and leaves bit 0 as it was.
- R8: When `abort_in` is high in a busy cycle, `wr_busy` is low in the next cycle. Status bit 0 (write-aborted) is then set and bit 1 keeps its value. An abort in the final busy cycle still counts as an abort.
- R9: A write that completes its WR_CYCLES busy cycles with no abort pulses `wr_done` in its last busy cycle and clears both status bits.
- R10: Status bits 7..2 always read zero.
- R11: `abort_in` while idle has no effect on the status byte or on `wr_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_pg | input | 8 | First page of the protected range (inside the range) |
| open_pg | input | 8 | First page after the protected range (writable) |
| wr_req | input | 1 | Write request |
| wr_page | input | 8 | Page targeted by the request |
| abort_in | input | 1 | Abort cause for a busy write |
| wr_ack | output | 1 | Request taken this cycle (combinational) |
| wr_err | output | 1 | Request refused as protected (with wr_ack) |
| wr_busy | output | 1 | A write is in progress |
| wr_done | output | 1 | Last busy cycle of a successful write |
| mem_wr_stb | output | 1 | One-cycle write start to the memory |
| mem_wr_page | output | 8 | Page passed to the memory |
| stat_byte | output | 8 | Status: bit 1 page-protected, bit 0 write-aborted |

## Verification
The range check is tried with a normal window on the pages just below, at, inside and at the upper edge, which separates an off-by-one at either bound. It is also tried with inverted and empty windows, which show whether a wrapped comparison protects pages it should not, and with the full 00h..FFh span. Abort is injected in the middle busy cycle and in the final one, so a success that wins over a late abort is caught. Refusals and aborts are interleaved with successes, which shows whether each flag is set, kept and cleared on its own.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_BUSY = 1'b1
  } seq_state_t;

  // Half-open window test: lo <= pg < hi, empty when hi <= lo.
  function automatic logic page_in_window(input logic [7:0] lo,
                                          input logic [7:0] hi,
                                          input logic [7:0] pg);
    logic above_lo;
    logic below_hi;
    above_lo = (pg >= lo);
    below_hi = (pg < hi);
    return (hi > lo) && above_lo && below_hi;
  endfunction

  // Status byte image: upper bits zero, protected flag, aborted flag.
  function automatic logic [7:0] status_image(input logic prot,
                                              input logic abrt);
    return {6'b000000, prot, abrt};
  endfunction

endpackage

// File: rtl/wprot_window.sv
module wprot_window #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] lock_pg,
  input  logic [PAGE_W-1:0] open_pg,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  logic [PAGE_W-1:0] span;
  logic [PAGE_W-1:0] offs;
  logic              nonempty;

  // Same test as the package function, written as an offset compare.
  always_comb begin
    nonempty = (open_pg > lock_pg);
    span     = open_pg - lock_pg;
    offs     = page - lock_pg;
    hit      = nonempty && (offs < span);
  end
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq #(
  parameter int WR_CYCLES = 4,
  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort_in,
  output logic busy,
  output logic abort_hit,
  output logic finish_ok
);
  import wprot_pkg::*;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cyc;

  assign busy      = (state_q == SQ_BUSY);
  assign last_cyc  = busy && (cnt_q == '0);
  assign abort_hit = busy && abort_in;
  assign finish_ok = last_cyc && !abort_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_BUSY;
            cnt_q   <= CNT_W'(WR_CYCLES - 1);
          end
        end
        SQ_BUSY: begin
          if (abort_in || (cnt_q == '0)) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wprot_status.sv
module wprot_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_prot,
  input  logic       set_abrt,
  input  logic       clr_all,
  output logic [7:0] stat
);
  import wprot_pkg::*;

  logic prot_q;
  logic abrt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      abrt_q <= 1'b0;
    end else begin
      if (clr_all) begin
        prot_q <= 1'b0;
        abrt_q <= 1'b0;
      end else begin
        if (set_prot) prot_q <= 1'b1;
        if (set_abrt) abrt_q <= 1'b1;
      end
    end
  end

  assign stat = status_image(prot_q, abrt_q);
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int WR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] lock_pg,
  input  logic [7:0] open_pg,
  input  logic       wr_req,
  input  logic [7:0] wr_page,
  input  logic       abort_in,
  output logic       wr_ack,
  output logic       wr_err,
  output logic       wr_busy,
  output logic       wr_done,
  output logic       mem_wr_stb,
  output logic [7:0] mem_wr_page,
  output logic [7:0] stat_byte
);
  // Named internal events, kept visible for the checker.
  logic win_hit;
  logic req_take;
  logic refuse_ev;
  logic accept_ev;
  logic abort_ev;
  logic success_ev;

  wprot_window #(.PAGE_W(8)) u_win (
    .lock_pg (lock_pg),
    .open_pg (open_pg),
    .page    (wr_page),
    .hit     (win_hit)
  );

  assign req_take  = wr_req && !wr_busy;
  assign refuse_ev = req_take && win_hit;
  assign accept_ev = req_take && !win_hit;

  wprot_seq #(.WR_CYCLES(WR_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_ev),
    .abort_in  (abort_in),
    .busy      (wr_busy),
    .abort_hit (abort_ev),
    .finish_ok (success_ev)
  );

  wprot_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_prot (refuse_ev),
    .set_abrt (abort_ev),
    .clr_all  (success_ev),
    .stat     (stat_byte)
  );

  assign wr_ack      = req_take;
  assign wr_err      = refuse_ev;
  assign mem_wr_stb  = accept_ev;
  assign mem_wr_page = wr_page;
  assign wr_done     = success_ev;
endmodule

// File: rtl/wprot_gate_chk.sv
module wprot_gate_chk #(
  parameter int WR_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] lock_pg,
  input logic [7:0] open_pg,
  input logic       wr_req,
  input logic [7:0] wr_page,
  input logic       abort_in,
  input logic       wr_ack,
  input logic       wr_err,
  input logic       wr_busy,
  input logic       wr_done,
  input logic       mem_wr_stb,
  input logic [7:0] stat_byte
);
  localparam int BW = $clog2(WR_CYCLES + 2);
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (wr_busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  // R2: a refusal never reaches the memory
  a_r2_refuse_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wr_err) |-> !mem_wr_stb);

  // R3: the lock page is refused whenever the range is not empty
  a_r3_lock_page_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_busy && (wr_page == lock_pg) && (open_pg > lock_pg)) |-> wr_err);

  // R4: an empty range refuses nothing
  a_r4_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (open_pg <= lock_pg) |-> !wr_err);

  // R5: a strobe starts the busy period, which never exceeds WR_CYCLES
  a_r5_stb_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_stb |=> wr_busy);
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (busy_run < BW'(WR_CYCLES)));

  // R6: nothing is taken while busy
  a_r6_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (!wr_ack && !mem_wr_stb));

  // R7: a refusal sets the protected flag and keeps the aborted flag
  a_r7_prot_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wr_err) |=> (stat_byte[1] && (stat_byte[0] == $past(stat_byte[0]))));

  // R8: an abort ends the write and sets the aborted flag
  a_r8_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && abort_in) |=> (!wr_busy && stat_byte[0] && (stat_byte[1] == $past(stat_byte[1]))));

  // R9: success clears both flags
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (!wr_busy && (stat_byte[1:0] == 2'b00)));

  // R11: abort while idle with no request changes nothing
  a_r11_idle_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_busy && !wr_req && abort_in) |=> ($stable(stat_byte) && !wr_busy));
endmodule

bind wprot_gate wprot_gate_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_pg    (lock_pg),
  .open_pg    (open_pg),
  .wr_req     (wr_req),
  .wr_page    (wr_page),
  .abort_in   (abort_in),
  .wr_ack     (wr_ack),
  .wr_err     (wr_err),
  .wr_busy    (wr_busy),
  .wr_done    (wr_done),
  .mem_wr_stb (mem_wr_stb),
  .stat_byte  (stat_byte)
);

// File: tb/wprot_gate_tb.sv
module wprot_gate_tb;
  localparam int W = 4;
  localparam int NV = 12;

  // Vector fields: {lock, open, page, abort_cycle (0 = none)}
  localparam logic [31:0] VEC [NV] = '{
    {8'd10,  8'd20,  8'd10,  8'd0},   // R3 lock page refused
    {8'd10,  8'd20,  8'd20,  8'd0},   // R3 open page accepted
    {8'd10,  8'd20,  8'd15,  8'd0},   // R2 inside
    {8'd10,  8'd20,  8'd9,   8'd0},   // just below
    {8'd20,  8'd10,  8'd15,  8'd0},   // R4 inverted
    {8'd30,  8'd30,  8'd30,  8'd0},   // R4 empty
    {8'd0,   8'd255, 8'd254, 8'd0},   // full span top inside
    {8'd0,   8'd255, 8'd255, 8'd2},   // R8 abort mid
    {8'd50,  8'd60,  8'd55,  8'd0},   // R7 keep abort flag
    {8'd50,  8'd60,  8'd70,  8'd4},   // R8 abort in last cycle
    {8'd50,  8'd60,  8'd70,  8'd0},   // R9 clears both
    {8'd0,   8'd0,   8'd0,   8'd0}    // R4 reset values
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] lock_pg = '0, open_pg = '0, wr_page = '0;
  logic wr_req = 1'b0, abort_in = 1'b0;
  logic wr_ack, wr_err, wr_busy, wr_done, mem_wr_stb;
  logic [7:0] mem_wr_page, stat_byte;

  int checks = 0;
  int errors = 0;
  logic prot_m = 1'b0, abrt_m = 1'b0;

  always #10 clk = ~clk;

  wprot_gate #(.WR_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock_pg(lock_pg), .open_pg(open_pg),
    .wr_req(wr_req), .wr_page(wr_page), .abort_in(abort_in),
    .wr_ack(wr_ack), .wr_err(wr_err), .wr_busy(wr_busy), .wr_done(wr_done),
    .mem_wr_stb(mem_wr_stb), .mem_wr_page(mem_wr_page), .stat_byte(stat_byte)
  );

  // Bench's own view: page is protected when its distance above lock
  // is smaller than the span, for a nonempty span.
  function automatic bit refused(input int lo, input int hi, input int pg);
    if (hi <= lo) return 0;
    return ((pg - lo + 256) % 256) < (hi - lo);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] v);
    int lo, hi, pg, k, n;
    bit rf;
    lo = int'(v[31:24]); hi = int'(v[23:16]); pg = int'(v[15:8]); k = int'(v[7:0]);
    rf = refused(lo, hi, pg);
    lock_pg = 8'(lo); open_pg = 8'(hi); wr_page = 8'(pg); wr_req = 1'b1;
    #1;
    chk("R5 ack", int'(wr_ack), 1);
    chk("R2 err", int'(wr_err), int'(rf));
    chk("R2 stb", int'(mem_wr_stb), int'(!rf));
    if (!rf) chk("R5 page", int'(mem_wr_page), pg);
    @(posedge clk); @(negedge clk);
    wr_req = 1'b0;
    if (rf) begin
      prot_m = 1'b1;
    end else begin
      n = 0;
      while (wr_busy && n < 100) begin
        n++;
        if (n == k) abort_in = 1'b1;
        #1;
        chk("R9 done", int'(wr_done), int'(n == W && n != k));
        @(negedge clk);
        abort_in = 1'b0;
      end
      chk("R5/R8 busy len", n, (k != 0) ? k : W);
      if (k != 0) abrt_m = 1'b1;
      else begin prot_m = 1'b0; abrt_m = 1'b0; end
    end
    chk("R7/R8/R9 status", int'(stat_byte), int'({6'b0, prot_m, abrt_m}));
    chk("R10 upper", int'(stat_byte[7:2]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", int'(stat_byte), 0);
    chk("R1 busy", int'(wr_busy), 0);
    chk("R1 stb", int'(mem_wr_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R11: abort while idle
    run_vec({8'd5, 8'd9, 8'd6, 8'd0});   // set protected flag first
    abort_in = 1'b1;
    repeat (2) @(negedge clk);
    abort_in = 1'b0;
    chk("R11 status", int'(stat_byte), int'({6'b0, prot_m, abrt_m}));
    chk("R11 busy", int'(wr_busy), 0);

    // R6: request while busy is ignored
    lock_pg = 8'd5; open_pg = 8'd9; wr_page = 8'd100; wr_req = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_page = 8'd101;
    #1;
    chk("R6 ack", int'(wr_ack), 0);
    chk("R6 stb", int'(mem_wr_stb), 0);
    wr_req = 1'b0;
    repeat (W + 1) @(negedge clk);
    chk("R6 idle after", int'(wr_busy), 0);
    chk("R9 status clear", int'(stat_byte), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule